// File: doc/BRIEF.md
# Quad-data-rate burst-of-four SRAM

This block is an on-chip static memory with a read port and a write port that work at the same time. The two ports share one address bus and one input clock. Each port has its own active-low select, sampled on the rising clock edge. Every access moves four words, one on each clock edge over two cycles. The stored array is made of registers. Its external address leaves out the two low bits that pick the beat, so each address names a group of four words. Word index is `{addr, beat}`, with beat 0..3.

A write is started by a low write select on a rising edge. That edge carries beat 0, and the next falling, rising and falling edges carry beats 1, 2 and 3. Each beat has one active-low enable per 9-bit lane. A read is started by a low read select on a rising edge. The four words appear on `rdata` starting two cycles later, one per edge, with `rvalid` and the output enable `rdata_oe` raised. The read bus is driven through a mux on the clock level, so beats 0 and 2 are shown while the clock is high and beats 1 and 3 while it is low.

Each port is run by its own state machine. The write machine has the states W_IDLE, W_HALF1 and W_HALF2:
- W_IDLE goes to W_HALF1 on a start.
- W_HALF1 always goes to W_HALF2.
- W_HALF2 goes to W_HALF1 on a new start, and to W_IDLE otherwise.

The read machine has the states R_IDLE, R_LOAD, R_HEAD, R_TAIL and R_TLOAD:
- R_IDLE goes to R_LOAD on a start.
- R_LOAD always goes to R_HEAD.
- R_HEAD goes to R_TLOAD on a start, and to R_TAIL otherwise.
- R_TAIL goes to R_LOAD on a start, and to R_IDLE otherwise.
- R_TLOAD always goes to R_HEAD.

Top module: `qb4_sram`

## Requirements
- R1: A low `rd_sel_n` at a rising edge starts a read of the four words at `addr` when the read port is free. The port is free when idle, or in the cycle of the first output pair, or in the cycle of the second output pair with no newer read pending.
- R2: Read latency and order:
  - Beat 0 of a read appears after the rising edge two cycles after the start edge.
  - Beats 1, 2 and 3 follow after the next falling, rising and falling edges.
  - Beat k is the word at index `{addr, k}`.
- R3: Valid and output enable:
  - `rvalid` and `rdata_oe` are high exactly during the four beat half-cycles of each read.
  - At all other times both are low and `rdata` is zero.
  - A burst already started still completes after `rd_sel_n` rises.
- R4: A low `wr_sel_n` at a rising edge starts a write to `addr` when the write port is free. Beat 0 is `wdata`/`bw_n` on that rising edge. Beats 1, 2 and 3 are taken on the next falling, rising and falling edges.
- R5: Byte lanes:
  - `bw_n[i]` is active low and qualifies bits `9i+8:9i` of the beat it is sampled with.
  - A lane whose enable is high leaves the stored 9 bits unchanged.
- R6: While `wr_sel_n` is high and the write port is idle, `wdata` and `bw_n` have no effect on the array.
- R7: Port spacing:
  - A select held low at the rising edge one cycle after its port's start is ignored.
  - Reads started two cycles apart give an unbroken run of valid beats.
- R8: Read and write ordering:
  - A read and a write started at the same edge, necessarily to the same address, return the data held before that write.
  - A write started two or more cycles before a read is fully visible to it.
- R9: After reset, `rvalid`, `rdata_oe` and `rdata` are low and both ports are idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_k | input | 1 | Input clock; rising and falling edges both carry beats |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_sel_n | input | 1 | Active-low read select, sampled on rising edges |
| wr_sel_n | input | 1 | Active-low write select, sampled on rising edges |
| addr | input | AW | Shared burst address (four words per address) |
| wdata | input | DW | Write data, sampled on both edges during a write |
| bw_n | input | DW/9 | Active-low per-lane write enables, sampled with data |
| rdata | output | DW | Read data, one beat per half-cycle |
| rvalid | output | 1 | High while a read beat is on `rdata` |
| rdata_oe | output | 1 | Output enable standing for the tri-state driver |

## Verification
The bench keeps a half-edge counter. For a read whose select is driven before rising edge P0, the expected beat k is due at the edge P0 + 4 + k, counted in half-cycles. These expected beats go into a queue. Each beat is compared 1 ns after its edge, and any beat that comes early, comes late or appears unexpected fails. The expected words come from a bench model of the array, updated when each write is issued. A read that starts at the same edge as a write is queued from the model before the write is applied. Reads are never issued one cycle after a write starts, which matches the two-cycle visibility rule.

// File: rtl/qb4_pkg.sv
package qb4_pkg;
    localparam int LANE_W = 9;
    localparam int BEATS  = 4;

    typedef enum logic [1:0] {
        W_IDLE,
        W_HALF1,
        W_HALF2
    } wr_state_t;

    typedef enum logic [2:0] {
        R_IDLE,
        R_LOAD,
        R_HEAD,
        R_TAIL,
        R_TLOAD
    } rd_state_t;
endpackage

// File: rtl/qb4_wr_ctrl.sv
module qb4_wr_ctrl
    import qb4_pkg::*;
#(
    parameter int AW    = 8,
    parameter int DW    = 18,
    parameter int LANES = DW / LANE_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_sel_n,
    input  logic [AW-1:0]    addr,
    input  logic [DW-1:0]    wdata,
    input  logic [LANES-1:0] bw_n,
    output logic             wr_start,
    output logic             commit_en,
    output logic             commit_hi,
    output logic [AW-1:0]    commit_addr,
    output logic [DW-1:0]    even_data,
    output logic [LANES-1:0] even_bw_n,
    output logic [DW-1:0]    odd_data,
    output logic [LANES-1:0] odd_bw_n
);
    wr_state_t state, state_nxt;

    logic [DW-1:0]    held_d;
    logic [LANES-1:0] held_bw;
    logic [DW-1:0]    fall_d;
    logic [LANES-1:0] fall_bw;
    logic [AW-1:0]    cur_addr;

    assign wr_start = !wr_sel_n && (state == W_IDLE || state == W_HALF2);

    always_comb begin
        state_nxt = state;
        unique case (state)
            W_IDLE:  if (!wr_sel_n) state_nxt = W_HALF1;
            W_HALF1: state_nxt = W_HALF2;
            W_HALF2: state_nxt = wr_sel_n ? W_IDLE : W_HALF1;
            default: state_nxt = W_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= W_IDLE;
        else        state <= state_nxt;
    end

    // odd beats arrive on the falling edge
    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fall_d  <= '0;
            fall_bw <= '1;
        end else begin
            fall_d  <= wdata;
            fall_bw <= bw_n;
        end
    end

    // even beats and the burst address arrive on the rising edge
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            held_d   <= '0;
            held_bw  <= '1;
            cur_addr <= '0;
        end else if (wr_start) begin
            cur_addr <= addr;
            held_d   <= wdata;
            held_bw  <= bw_n;
        end else if (state == W_HALF1) begin
            held_d   <= wdata;
            held_bw  <= bw_n;
        end
    end

    assign commit_en   = (state != W_IDLE);
    assign commit_hi   = (state == W_HALF2);
    assign commit_addr = cur_addr;
    assign even_data   = held_d;
    assign even_bw_n   = held_bw;
    assign odd_data    = fall_d;
    assign odd_bw_n    = fall_bw;
endmodule

// File: rtl/qb4_array.sv
module qb4_array
    import qb4_pkg::*;
#(
    parameter int AW    = 8,
    parameter int DW    = 18,
    parameter int LANES = DW / LANE_W
) (
    input  logic                       clk,
    input  logic                       we,
    input  logic                       whi,
    input  logic [AW-1:0]              waddr,
    input  logic [DW-1:0]              d_even,
    input  logic [LANES-1:0]           be_even_n,
    input  logic [DW-1:0]              d_odd,
    input  logic [LANES-1:0]           be_odd_n,
    input  logic [AW-1:0]              raddr,
    output logic [BEATS-1:0][DW-1:0]   rwords
);
    localparam int WORDS = (1 << AW) * BEATS;
    localparam int IW    = AW + 2;

    logic [DW-1:0] mem [WORDS];
    logic [IW-1:0] idx_even;
    logic [IW-1:0] idx_odd;

    assign idx_even = {waddr, whi, 1'b0};
    assign idx_odd  = {waddr, whi, 1'b1};

    always_ff @(posedge clk) begin
        if (we) begin
            for (int l = 0; l < LANES; l++) begin
                if (!be_even_n[l]) mem[idx_even][l*LANE_W +: LANE_W] <= d_even[l*LANE_W +: LANE_W];
                if (!be_odd_n[l])  mem[idx_odd][l*LANE_W +: LANE_W]  <= d_odd[l*LANE_W +: LANE_W];
            end
        end
    end

    for (genvar b = 0; b < BEATS; b++) begin : g_rd
        assign rwords[b] = mem[{raddr, 2'(b)}];
    end
endmodule

// File: rtl/qb4_rd_ctrl.sv
module qb4_rd_ctrl
    import qb4_pkg::*;
#(
    parameter int AW = 8,
    parameter int DW = 18
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     rd_sel_n,
    input  logic [AW-1:0]            addr,
    input  logic [BEATS-1:0][DW-1:0] rwords,
    output logic [AW-1:0]            raddr,
    output logic                     rd_start,
    output logic                     v_rise_o,
    output logic [DW-1:0]            rdata,
    output logic                     rvalid
);
    rd_state_t state, state_nxt;

    logic [BEATS-1:0][DW-1:0] line_q;
    logic [DW-1:0] q_rise, q_fall, q_stage;
    logic          v_rise, v_fall, v_stage;

    assign rd_start = !rd_sel_n &&
                      (state == R_IDLE || state == R_HEAD || state == R_TAIL);

    always_comb begin
        state_nxt = state;
        unique case (state)
            R_IDLE:  if (!rd_sel_n) state_nxt = R_LOAD;
            R_LOAD:  state_nxt = R_HEAD;
            R_HEAD:  state_nxt = rd_sel_n ? R_TAIL : R_TLOAD;
            R_TAIL:  state_nxt = rd_sel_n ? R_IDLE : R_LOAD;
            R_TLOAD: state_nxt = R_HEAD;
            default: state_nxt = R_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= R_IDLE;
        else        state <= state_nxt;
    end

    // address capture and array fetch
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            raddr  <= '0;
            line_q <= '0;
        end else begin
            if (rd_start) raddr <= addr;
            if (state == R_LOAD || state == R_TLOAD) line_q <= rwords;
        end
    end

    // rising-edge output stage; the falling beat is staged alongside
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q_rise  <= '0;
            q_stage <= '0;
            v_rise  <= 1'b0;
            v_stage <= 1'b0;
        end else begin
            unique case (state)
                R_HEAD: begin
                    q_rise  <= line_q[0];
                    q_stage <= line_q[1];
                    v_rise  <= 1'b1;
                    v_stage <= 1'b1;
                end
                R_TAIL, R_TLOAD: begin
                    q_rise  <= line_q[2];
                    q_stage <= line_q[3];
                    v_rise  <= 1'b1;
                    v_stage <= 1'b1;
                end
                default: begin
                    q_rise  <= '0;
                    q_stage <= '0;
                    v_rise  <= 1'b0;
                    v_stage <= 1'b0;
                end
            endcase
        end
    end

    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q_fall <= '0;
            v_fall <= 1'b0;
        end else begin
            q_fall <= q_stage;
            v_fall <= v_stage;
        end
    end

    assign rdata    = clk ? q_rise : q_fall;
    assign rvalid   = clk ? v_rise : v_fall;
    assign v_rise_o = v_rise;
endmodule

// File: rtl/qb4_sram.sv
module qb4_sram
    import qb4_pkg::*;
#(
    parameter int AW = 8,
    parameter int DW = 18
) (
    input  logic                   clk_k,
    input  logic                   rst_n,
    input  logic                   rd_sel_n,
    input  logic                   wr_sel_n,
    input  logic [AW-1:0]          addr,
    input  logic [DW-1:0]          wdata,
    input  logic [DW/LANE_W-1:0]   bw_n,
    output logic [DW-1:0]          rdata,
    output logic                   rvalid,
    output logic                   rdata_oe
);
    localparam int LANES = DW / LANE_W;

    logic                     wr_start;
    logic                     w_commit;
    logic                     w_hi;
    logic [AW-1:0]            w_addr;
    logic [DW-1:0]            w_even_d, w_odd_d;
    logic [LANES-1:0]         w_even_bw, w_odd_bw;
    logic [AW-1:0]            r_addr;
    logic [BEATS-1:0][DW-1:0] r_words;
    logic                     rd_start;
    logic                     v_rise;

    qb4_wr_ctrl #(.AW(AW), .DW(DW), .LANES(LANES)) u_wr (
        .clk         (clk_k),
        .rst_n       (rst_n),
        .wr_sel_n    (wr_sel_n),
        .addr        (addr),
        .wdata       (wdata),
        .bw_n        (bw_n),
        .wr_start    (wr_start),
        .commit_en   (w_commit),
        .commit_hi   (w_hi),
        .commit_addr (w_addr),
        .even_data   (w_even_d),
        .even_bw_n   (w_even_bw),
        .odd_data    (w_odd_d),
        .odd_bw_n    (w_odd_bw)
    );

    qb4_array #(.AW(AW), .DW(DW), .LANES(LANES)) u_mem (
        .clk       (clk_k),
        .we        (w_commit),
        .whi       (w_hi),
        .waddr     (w_addr),
        .d_even    (w_even_d),
        .be_even_n (w_even_bw),
        .d_odd     (w_odd_d),
        .be_odd_n  (w_odd_bw),
        .raddr     (r_addr),
        .rwords    (r_words)
    );

    qb4_rd_ctrl #(.AW(AW), .DW(DW)) u_rd (
        .clk      (clk_k),
        .rst_n    (rst_n),
        .rd_sel_n (rd_sel_n),
        .addr     (addr),
        .rwords   (r_words),
        .raddr    (r_addr),
        .rd_start (rd_start),
        .v_rise_o (v_rise),
        .rdata    (rdata),
        .rvalid   (rvalid)
    );

    assign rdata_oe = rvalid;
endmodule

// File: rtl/qb4_sram_chk.sv
module qb4_sram_chk #(
    parameter int DW = 18
) (
    input logic          clk,
    input logic          rst_n,
    input logic          rd_start,
    input logic          wr_start,
    input logic          wr_commit,
    input logic          v_rise,
    input logic          rvalid,
    input logic [DW-1:0] rdata
);
    a_r2_first_beat: assert property (@(posedge clk) disable iff (!rst_n)
        rd_start |-> ##3 v_rise);

    a_r3_pair_length: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(v_rise) |=> v_rise);

    a_r3_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !rvalid |-> rdata == '0);

    a_r4_commit_first: assert property (@(posedge clk) disable iff (!rst_n)
        wr_start |=> wr_commit);

    a_r4_commit_second: assert property (@(posedge clk) disable iff (!rst_n)
        wr_start |-> ##2 wr_commit);

    a_r6_commit_source: assert property (@(posedge clk) disable iff (!rst_n)
        wr_commit |-> ($past(wr_start) || $past(wr_start, 2)));

    a_r7_read_busy: assert property (@(posedge clk) disable iff (!rst_n)
        rd_start |=> !rd_start);

    a_r7_write_busy: assert property (@(posedge clk) disable iff (!rst_n)
        wr_start |=> !wr_start);
endmodule

bind qb4_sram qb4_sram_chk #(.DW(DW)) u_chk (
    .clk       (clk_k),
    .rst_n     (rst_n),
    .rd_start  (rd_start),
    .wr_start  (wr_start),
    .wr_commit (w_commit),
    .v_rise    (v_rise),
    .rvalid    (rvalid),
    .rdata     (rdata)
);

// File: tb/tb_qb4_sram.sv
module tb_qb4_sram;
    localparam int AW    = 8;
    localparam int DW    = 18;
    localparam int LN    = DW / 9;
    localparam int WORDS = (1 << AW) * 4;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          rd_sel_n, wr_sel_n;
    logic [AW-1:0] addr;
    logic [DW-1:0] wdata;
    logic [LN-1:0] bw_n;
    logic [DW-1:0] rdata;
    logic          rvalid, rdata_oe;

    qb4_sram #(.AW(AW), .DW(DW)) dut (
        .clk_k(clk), .rst_n(rst_n), .rd_sel_n(rd_sel_n), .wr_sel_n(wr_sel_n),
        .addr(addr), .wdata(wdata), .bw_n(bw_n),
        .rdata(rdata), .rvalid(rvalid), .rdata_oe(rdata_oe)
    );

    always #4 clk = ~clk;   // 125 MHz

    typedef struct {
        int            due;
        logic [DW-1:0] val;
        string         req;
    } exp_t;

    exp_t          sb[$];
    logic [DW-1:0] model [WORDS];
    int            hc = 0;
    int            total = 0;
    int            bad = 0;

    task automatic chk(input bit ok, input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h at edge %0d", req, act, exp, hc);
        end
    endtask

    // monitor: one sample per half-cycle, 1 ns after the edge
    always @(clk) begin
        hc++;
        #1;
        if (rst_n === 1'b1) begin
            if (rdata_oe !== rvalid) chk(0, "R3 oe", DW'(rdata_oe), DW'(rvalid));
            while (sb.size() > 0 && sb[0].due < hc) begin
                chk(0, {sb[0].req, " missed beat"}, rdata, sb[0].val);
                void'(sb.pop_front());
            end
            if (sb.size() > 0 && sb[0].due == hc) begin
                chk(rvalid === 1'b1 && rdata === sb[0].val, sb[0].req, rdata, sb[0].val);
                void'(sb.pop_front());
            end else if (rvalid !== 1'b0) begin
                chk(0, "R3 unexpected valid", rdata, '0);
            end else if (rdata !== '0) begin
                chk(0, "R3 idle data", rdata, '0);
            end
        end
    end

    function automatic logic [DW-1:0] pat(input int a, input int k, input int s);
        return DW'((a * 97 + k * 29 + s * 113 + 7) ^ (a << 10) ^ (k << 15));
    endfunction

    // one burst: two cycles; optional select held low in the busy cycle
    task automatic burst(input bit rd, input bit wr, input int a,
                         input logic [3:0][DW-1:0] d, input logic [3:0][LN-1:0] bw,
                         input bit rd_hold, input bit wr_hold, input int a2, input string tag);
        @(negedge clk); #2;
        if (rd)
            for (int k = 0; k < 4; k++) sb.push_back('{hc + 5 + k, model[a*4+k], tag});
        if (wr)
            for (int k = 0; k < 4; k++)
                for (int l = 0; l < LN; l++)
                    if (!bw[k][l]) model[a*4+k][l*9 +: 9] = d[k][l*9 +: 9];
        rd_sel_n = !rd; wr_sel_n = !wr; addr = AW'(a); wdata = d[0]; bw_n = bw[0];
        @(posedge clk); #2;
        wdata = d[1]; bw_n = bw[1];
        @(negedge clk); #2;
        rd_sel_n = !rd_hold; wr_sel_n = !wr_hold; addr = AW'(a2);
        wdata = d[2]; bw_n = bw[2];
        @(posedge clk); #2;
        wdata = d[3]; bw_n = bw[3];
        rd_sel_n = 1'b1; wr_sel_n = 1'b1;
    endtask

    task automatic wr_full(input int a, input int s, input string tag);
        logic [3:0][DW-1:0] d;
        for (int k = 0; k < 4; k++) d[k] = pat(a, k, s);
        burst(0, 1, a, d, '0, 0, 0, 0, tag);
    endtask

    task automatic rd_only(input int a, input string tag);
        burst(1, 0, a, '0, '1, 0, 0, 0, tag);
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
    endtask

    initial begin
        #800000;
        chk(0, "watchdog", '0, '0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [3:0][DW-1:0] d;
        rst_n = 1'b0; rd_sel_n = 1'b1; wr_sel_n = 1'b1;
        addr = '0; wdata = '0; bw_n = '1;
        repeat (4) @(posedge clk);
        @(negedge clk); #2; rst_n = 1'b1;
        @(posedge clk); #1;
        // R9: outputs idle after reset
        chk(rvalid === 1'b0 && rdata_oe === 1'b0 && rdata === '0, "R9 reset", rdata, '0);

        // R4: fill the array with back-to-back writes
        for (int a = 0; a < (1 << AW); a++) wr_full(a, 0, "R4");

        // R1 R2 R7: back-to-back reads give continuous beats
        for (int a = 0; a < 8; a++) rd_only(a * 31 % 256, "R2 back-to-back");
        idle(3);
        // R1: reads with gaps of one and two cycles
        rd_only(200, "R1 gap"); idle(1);
        rd_only(201, "R1 gap"); idle(2);
        rd_only(255, "R1 gap"); idle(4);

        // R5: per-beat lane enables
        for (int k = 0; k < 4; k++) d[k] = pat(10, k, 5);
        burst(0, 1, 10, d, {2'b00, 2'b11, 2'b10, 2'b01}, 0, 0, 0, "R5");
        rd_only(10, "R5 lanes");
        idle(2);

        // R6: data with write select high is ignored
        for (int k = 0; k < 4; k++) d[k] = ~pat(20, k, 0);
        burst(0, 0, 20, d, '0, 0, 0, 0, "R6");
        rd_only(20, "R6 ignored");
        idle(2);

        // R7: selects held low in the busy cycle are ignored
        burst(1, 0, 50, '0, '1, 1, 0, 51, "R7 read hold");
        idle(4);
        for (int k = 0; k < 4; k++) d[k] = pat(30, k, 9);
        burst(0, 1, 30, d, '0, 0, 1, 31, "R7");
        rd_only(31, "R7 write hold");
        rd_only(30, "R7 write data");
        idle(2);

        // R8: same-edge read and write return old data, then new
        for (int k = 0; k < 4; k++) d[k] = pat(40, k, 3);
        burst(1, 1, 40, d, '0, 0, 0, 0, "R8 old");
        rd_only(40, "R8 new");
        for (int k = 0; k < 4; k++) d[k] = pat(41, k, 4);
        burst(1, 1, 41, d, {2'b10, 2'b01, 2'b00, 2'b11}, 0, 0, 0, "R8 old lanes");
        rd_only(41, "R8 R5 new lanes");

        // R4 R3: write burst chain, then reads, then read select released
        wr_full(60, 7, "R4"); wr_full(61, 7, "R4"); wr_full(62, 7, "R4");
        rd_only(62, "R4 chain"); rd_only(60, "R4 chain"); rd_only(61, "R3 last");
        idle(8);
        chk(sb.size() == 0, "R3 burst completion", DW'(sb.size()), '0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule